// File: doc/BRIEF.md
# Receive Packet Status Queue

This block sits between a MAC receive stream and a host. Frame bytes from the MAC are written into a byte-wide data FIFO, and a small ring keeps one entry for each packet: its stored length, whether it has finished arriving, and the error class the MAC reported when it ended. The host sees one 16-bit status word that describes the packet at the head of the queue. It reads that packet's bytes as 16-bit words and removes the packet with a discard command.

Space is limited in two ways. The ring holds at most eight packets, and the data FIFO holds a fixed number of bytes. When either limit is reached, frames that start are refused whole. A frame that fills the FIFO while it is arriving is cut short and marked as an overrun. A frame longer than the maximum length is cut at that length and marked as oversize. If the host reads past the bytes received so far, a sticky underrun flag is set and adapter failure is raised. An RX reset command empties the whole queue.

Top module: `rxq_status_queue`

## Requirements
- R1: After reset or RX reset the status word is 0x8000, and `rx_complete`, `receiving`, `pkt_limit_hit`, `fifo_full_flag`, `rx_underrun` and `adapter_fail` are all low.
- R2: Status bit 15 is 1 while the queue is empty or the head packet is still arriving. While the head is arriving, bits 14:11 are 0 and bits 10:0 give the number of bytes stored so far.
- R3: For a finished head packet, bit 15 is 0, bits 10:0 give its stored byte count, and bits 14:11 give its class. The class codes are 1000 overrun, 1001 oversize, 1011 runt, 1100 alignment, 1101 CRC and 0010 dribble. Any other MAC code is shown as 0000. Bit 14 is therefore set exactly for the error classes.
- R4: A frame longer than MAX_LEN bytes keeps only its first MAX_LEN bytes, shows a count of MAX_LEN and has class 1001, unless it is also an overrun. The count never exceeds MAX_LEN.
- R5: When 8 packets are held (including one still arriving), `pkt_limit_hit` is high and a frame that starts is refused: no entry is made and no bytes are stored. The flag drops in the cycle after a discard removes a packet.
- R6: `fifo_full_flag` is high while the data FIFO is full, and a frame that starts while it is full is refused. Bytes of an accepted frame that arrive while the FIFO is full are dropped, and the packet gets class 1000. Class 1000 takes priority over 1001. The flag drops after the host reads bytes out.
- R7: `host_rdata` shows the next unread bytes of the head packet, with the earlier byte in bits 7:0. Each `host_rd` pulse consumes two bytes. If only one byte remains, bits 15:8 read 0 and one byte is consumed.
- R8: A `host_rd` when no unread byte of the head packet remains (or the queue is empty) sets `rx_underrun` and `adapter_fail`. These stay set until RX reset or `rst_n`, and neither discard nor reads clears them.
- R9: `receiving` is high from the first accepted byte of a frame until the cycle after its last byte. It stays low for refused frames.
- R10: `cmd_discard` removes a finished head packet together with its unread bytes. It is ignored when the queue is empty or the head is still arriving. A `host_rd` in the same cycle as an effective discard has no effect.
- R11: `rx_complete` is high exactly while a finished packet is at the head of the queue.
- R12: `cmd_rx_reset` empties the packet ring and the data FIFO, clears `rx_underrun` and ends any frame in progress. The result is visible in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (global reset) |
| mac_valid | input | 1 | A frame byte is present this cycle |
| mac_byte | input | 8 | Frame byte |
| mac_last | input | 1 | This byte ends the frame |
| mac_err | input | 4 | Error kind from the MAC, sampled with the last byte |
| host_rd | input | 1 | Consume the word on host_rdata |
| cmd_discard | input | 1 | Discard the head packet |
| cmd_rx_reset | input | 1 | RX reset: flush queue and clear underrun |
| status_word | output | 16 | Head packet status |
| host_rdata | output | 16 | Next data word of the head packet |
| rx_complete | output | 1 | Finished packet at head |
| receiving | output | 1 | A frame is being written into the FIFO |
| pkt_limit_hit | output | 1 | Eight packets held |
| fifo_full_flag | output | 1 | Data FIFO full |
| rx_underrun | output | 1 | Sticky read-past-end flag |
| adapter_fail | output | 1 | Adapter failure indication |

## Verification
The hardest situation to reach is an accepted frame running into a full data FIFO partway through. To get there, the queue must already hold a long packet, and the next frame must start while space is still left. The bench uses a 32-byte FIFO and a 20-byte MAX_LEN, so two 20-byte frames cause this: the second is cut at 12 bytes, and a third frame then meets the full-FIFO refusal. The bench also fills the ring with eight short frames to reach the packet limit, starts a discard while the head is still arriving, and reads past an odd-length packet to set the underrun flag.

// File: rtl/rxq_pkg.sv
// rxq_pkg: shared widths, the error class encoding and the per-packet entry
// type of the receive status queue. Assumes an 11-bit length field.
package rxq_pkg;

    localparam int LENW = 11;

    typedef enum logic [3:0] {
        CLS_NONE     = 4'b0000,
        CLS_DRIBBLE  = 4'b0010,
        CLS_OVERRUN  = 4'b1000,
        CLS_OVERSIZE = 4'b1001,
        CLS_RUNT     = 4'b1011,
        CLS_ALIGN    = 4'b1100,
        CLS_CRC      = 4'b1101
    } rx_class_e;

    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_RECV = 2'd1,
        WR_DROP = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic            done;
        rx_class_e       cls;
        logic [LENW-1:0] len;
    } rx_entry_t;

    // Map a raw MAC error code onto the class set; unknown codes mean no error.
    function automatic rx_class_e normalize_class(input logic [3:0] raw);
        case (raw)
            4'b0010: return CLS_DRIBBLE;
            4'b1000: return CLS_OVERRUN;
            4'b1001: return CLS_OVERSIZE;
            4'b1011: return CLS_RUNT;
            4'b1100: return CLS_ALIGN;
            4'b1101: return CLS_CRC;
            default: return CLS_NONE;
        endcase
    endfunction

endpackage

// File: rtl/rxq_byte_fifo.sv
// rxq_byte_fifo: byte-wide circular data store. One byte can be pushed per
// cycle. The read side advances by any count up to the stored amount. Two
// bytes at the read pointer are always visible. Assumes DEPTH is a power of
// two and that the caller never pushes when full or advances past the fill.
module rxq_byte_fifo #(
    parameter int DEPTH = 512
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     flush,
    input  logic                     push,
    input  logic [7:0]               push_byte,
    input  logic                     adv_en,
    input  logic [$clog2(DEPTH):0]   adv_cnt,
    output logic [7:0]               peek_lo,
    output logic [7:0]               peek_hi,
    output logic                     full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] fill;
    logic [CW-1:0] adv_amt;

    assign adv_amt = adv_en ? adv_cnt : '0;

    // Store an incoming byte at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wptr] <= push_byte;
        end
    end

    // Move the pointers and keep the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
        end else begin
            if (push) begin
                wptr <= wptr + AW'(1);
            end
            if (adv_en) begin
                rptr <= rptr + adv_cnt[AW-1:0];
            end
            fill <= fill + CW'(push) - adv_amt;
        end
    end

    assign peek_lo = mem[rptr];
    assign peek_hi = mem[rptr + AW'(1)];
    assign full    = (fill == CW'(DEPTH));

endmodule

// File: rtl/rxq_entry_ring.sv
// rxq_entry_ring: ring of per-packet entries (done flag, class, stored length).
// An entry is allocated with the first stored byte of a frame. The youngest
// entry grows and is closed by the writer, and the head entry is popped by a
// discard. Assumes SLOTS is a power of two and that the writer never
// allocates when full.
module rxq_entry_ring
    import rxq_pkg::*;
#(
    parameter int SLOTS = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      flush,
    input  logic      alloc,
    input  logic      grow,
    input  logic      close,
    input  rx_class_e close_cls,
    input  logic      pop,
    output rx_entry_t head,
    output logic      head_valid,
    output logic      full
);
    localparam int IW = $clog2(SLOTS);
    localparam int NW = $clog2(SLOTS + 1);

    rx_entry_t     slot [SLOTS];
    logic [IW-1:0] hd;
    logic [IW-1:0] tl;
    logic [IW-1:0] open_idx;
    logic [NW-1:0] cnt;

    assign open_idx = tl - IW'(1);

    // Write a new entry, or update the youngest one.
    always_ff @(posedge clk) begin
        if (alloc) begin
            slot[tl].done <= close;
            slot[tl].cls  <= close ? close_cls : CLS_NONE;
            slot[tl].len  <= LENW'(1);
        end else begin
            if (grow) begin
                slot[open_idx].len <= slot[open_idx].len + LENW'(1);
            end
            if (close) begin
                slot[open_idx].done <= 1'b1;
                slot[open_idx].cls  <= close_cls;
            end
        end
    end

    // Move the ring pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            hd  <= '0;
            tl  <= '0;
            cnt <= '0;
        end else begin
            if (alloc) begin
                tl <= tl + IW'(1);
            end
            if (pop) begin
                hd <= hd + IW'(1);
            end
            cnt <= cnt + NW'(alloc) - NW'(pop);
        end
    end

    assign head       = slot[hd];
    assign head_valid = (cnt != '0);
    assign full       = (cnt == NW'(SLOTS));

endmodule

// File: rtl/rxq_frame_writer.sv
// rxq_frame_writer: accepts or refuses each MAC frame when its first byte
// arrives. It stores bytes up to MAX_LEN while FIFO space lasts and picks the
// class at the last byte (overrun, then oversize, then the MAC's own code).
// Assumes MAX_LEN fits the 11-bit length field.
module rxq_frame_writer
    import rxq_pkg::*;
#(
    parameter int MAX_LEN = 1514
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       beat,
    input  logic       beat_last,
    input  logic [3:0] beat_err,
    input  logic       ring_full,
    input  logic       fifo_full,
    output logic       push,
    output logic       alloc,
    output logic       grow,
    output logic       close,
    output rx_class_e  close_cls,
    output logic       receiving
);
    wr_state_e       state;
    wr_state_e       state_nx;
    logic [LENW-1:0] cur_len;
    logic            ovr_seen;
    logic            big_seen;
    logic            at_max;
    logic            ovr_nx;
    logic            big_nx;

    assign at_max = (cur_len == LENW'(MAX_LEN));
    assign ovr_nx = ovr_seen || (beat && !at_max && fifo_full);
    assign big_nx = big_seen || (beat && at_max);

    // Decide acceptance, storage and closing for the current beat.
    always_comb begin
        push      = 1'b0;
        alloc     = 1'b0;
        grow      = 1'b0;
        close     = 1'b0;
        close_cls = CLS_NONE;
        state_nx  = state;
        case (state)
            WR_IDLE: begin
                if (beat) begin
                    if (ring_full || fifo_full) begin
                        state_nx = beat_last ? WR_IDLE : WR_DROP;
                    end else begin
                        alloc     = 1'b1;
                        push      = 1'b1;
                        close     = beat_last;
                        close_cls = normalize_class(beat_err);
                        state_nx  = beat_last ? WR_IDLE : WR_RECV;
                    end
                end
            end
            WR_RECV: begin
                if (beat) begin
                    push  = !at_max && !fifo_full;
                    grow  = !at_max && !fifo_full;
                    close = beat_last;
                    if (ovr_nx) begin
                        close_cls = CLS_OVERRUN;
                    end else if (big_nx) begin
                        close_cls = CLS_OVERSIZE;
                    end else begin
                        close_cls = normalize_class(beat_err);
                    end
                    if (beat_last) begin
                        state_nx = WR_IDLE;
                    end
                end
            end
            WR_DROP: begin
                if (beat && beat_last) begin
                    state_nx = WR_IDLE;
                end
            end
            default: state_nx = WR_IDLE;
        endcase
    end

    // Hold the frame state, the running length and the truncation flags.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            state    <= WR_IDLE;
            cur_len  <= '0;
            ovr_seen <= 1'b0;
            big_seen <= 1'b0;
        end else begin
            state <= state_nx;
            if (alloc) begin
                cur_len  <= LENW'(1);
                ovr_seen <= 1'b0;
                big_seen <= 1'b0;
            end else if (state == WR_RECV) begin
                if (grow) begin
                    cur_len <= cur_len + LENW'(1);
                end
                ovr_seen <= ovr_nx;
                big_seen <= big_nx;
            end
        end
    end

    assign receiving = (state == WR_RECV);

endmodule

// File: rtl/rxq_status_queue.sv
// rxq_status_queue: receive packet status queue. It joins the frame writer,
// the byte FIFO and the entry ring. It forms the head status word, serves
// 16-bit host reads, and handles discard, RX reset and the sticky underrun.
// Assumes DEPTH_BYTES is a power of two no larger than 1024, and SLOTS is a
// power of two.
module rxq_status_queue
    import rxq_pkg::*;
#(
    parameter int DEPTH_BYTES = 512,
    parameter int MAX_LEN     = 1514,
    parameter int SLOTS       = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mac_valid,
    input  logic [7:0]  mac_byte,
    input  logic        mac_last,
    input  logic [3:0]  mac_err,
    input  logic        host_rd,
    input  logic        cmd_discard,
    input  logic        cmd_rx_reset,
    output logic [15:0] status_word,
    output logic [15:0] host_rdata,
    output logic        rx_complete,
    output logic        receiving,
    output logic        pkt_limit_hit,
    output logic        fifo_full_flag,
    output logic        rx_underrun,
    output logic        adapter_fail
);
    localparam int CW = $clog2(DEPTH_BYTES) + 1;

    logic            wr_push;
    logic            wr_alloc;
    logic            wr_grow;
    logic            wr_close;
    rx_class_e       wr_cls;
    logic            ring_full;
    logic            fifo_full;
    rx_entry_t       head;
    logic            head_valid;
    logic            head_done;
    logic [7:0]      peek_lo;
    logic [7:0]      peek_hi;
    logic [LENW-1:0] rd_cnt;
    logic [LENW-1:0] remain;
    logic [LENW-1:0] take;
    logic            discard_go;
    logic            read_go;
    logic            read_ok;
    logic            read_bad;
    logic            adv_en;
    logic [CW-1:0]   adv_cnt;
    logic            underrun_q;

    rxq_frame_writer #(.MAX_LEN(MAX_LEN)) u_writer (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd_rx_reset),
        .beat      (mac_valid),
        .beat_last (mac_last),
        .beat_err  (mac_err),
        .ring_full (ring_full),
        .fifo_full (fifo_full),
        .push      (wr_push),
        .alloc     (wr_alloc),
        .grow      (wr_grow),
        .close     (wr_close),
        .close_cls (wr_cls),
        .receiving (receiving)
    );

    rxq_byte_fifo #(.DEPTH(DEPTH_BYTES)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (cmd_rx_reset),
        .push      (wr_push),
        .push_byte (mac_byte),
        .adv_en    (adv_en),
        .adv_cnt   (adv_cnt),
        .peek_lo   (peek_lo),
        .peek_hi   (peek_hi),
        .full      (fifo_full)
    );

    rxq_entry_ring #(.SLOTS(SLOTS)) u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (cmd_rx_reset),
        .alloc      (wr_alloc),
        .grow       (wr_grow),
        .close      (wr_close),
        .close_cls  (wr_cls),
        .pop        (discard_go),
        .head       (head),
        .head_valid (head_valid),
        .full       (ring_full)
    );

    // Work out how many head bytes are unread and what a read or discard does.
    always_comb begin
        head_done  = head_valid && head.done;
        remain     = head_valid ? (head.len - rd_cnt) : '0;
        take       = (remain >= LENW'(2)) ? LENW'(2) : remain;
        discard_go = cmd_discard && head_done;
        read_go    = host_rd && !discard_go;
        read_ok    = read_go && (remain != '0);
        read_bad   = read_go && (remain == '0);
        adv_en     = discard_go || read_ok;
        adv_cnt    = discard_go ? remain[CW-1:0] : take[CW-1:0];
    end

    // Count bytes already consumed from the head packet.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_rx_reset) begin
            rd_cnt <= '0;
        end else if (discard_go) begin
            rd_cnt <= '0;
        end else if (read_ok) begin
            rd_cnt <= rd_cnt + take;
        end
    end

    // Sticky underrun; only RX reset or global reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || cmd_rx_reset) begin
            underrun_q <= 1'b0;
        end else if (read_bad) begin
            underrun_q <= 1'b1;
        end
    end

    // Assemble the head status word and the next host data word.
    always_comb begin
        if (!head_valid) begin
            status_word = 16'h8000;
        end else if (!head.done) begin
            status_word = {1'b1, 4'b0000, head.len};
        end else begin
            status_word = {1'b0, head.cls, head.len};
        end
        if (remain >= LENW'(2)) begin
            host_rdata = {peek_hi, peek_lo};
        end else if (remain == LENW'(1)) begin
            host_rdata = {8'h00, peek_lo};
        end else begin
            host_rdata = 16'h0000;
        end
    end

    assign rx_complete    = head_done;
    assign pkt_limit_hit  = ring_full;
    assign fifo_full_flag = fifo_full;
    assign rx_underrun    = underrun_q;
    assign adapter_fail   = underrun_q;

endmodule

// File: rtl/rxq_status_queue_chk.sv
// rxq_status_queue_chk: port-level properties of the receive status queue,
// bound to every instance of the top module.
module rxq_status_queue_chk #(
    parameter int MAX_LEN = 1514
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mac_valid,
    input logic        host_rd,
    input logic        cmd_discard,
    input logic        cmd_rx_reset,
    input logic [15:0] status_word,
    input logic        rx_complete,
    input logic        receiving,
    input logic        pkt_limit_hit,
    input logic        rx_underrun,
    input logic        adapter_fail
);
    a_r2_open_has_no_class: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[15] |-> (status_word[14:11] == 4'b0000));

    a_r4_count_capped: assert property (@(posedge clk) disable iff (!rst_n)
        32'(status_word[10:0]) <= MAX_LEN);

    a_r5_limit_needs_discard: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_limit_hit && !cmd_discard && !cmd_rx_reset) |=> pkt_limit_hit);

    a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_underrun && !cmd_rx_reset) |=> rx_underrun);

    a_r8_underrun_from_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_underrun) |-> $past(host_rd));

    a_r8_failure_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        rx_underrun |-> adapter_fail);

    a_r9_receiving_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (receiving && !mac_valid && !cmd_rx_reset) |=> receiving);

    a_r11_complete_status: assert property (@(posedge clk) disable iff (!rst_n)
        rx_complete |-> !status_word[15]);

    a_r12_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rx_reset |=> ((status_word == 16'h8000) && !rx_underrun && !receiving));

endmodule

bind rxq_status_queue rxq_status_queue_chk #(.MAX_LEN(MAX_LEN)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mac_valid     (mac_valid),
    .host_rd       (host_rd),
    .cmd_discard   (cmd_discard),
    .cmd_rx_reset  (cmd_rx_reset),
    .status_word   (status_word),
    .rx_complete   (rx_complete),
    .receiving     (receiving),
    .pkt_limit_hit (pkt_limit_hit),
    .rx_underrun   (rx_underrun),
    .adapter_fail  (adapter_fail)
);

// File: tb/tb_rxq_status_queue.sv
`timescale 1ns/1ps
module tb_rxq_status_queue;
    localparam int DEPTH = 32;
    localparam int MAXL  = 20;
    localparam int SLOTS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mac_valid = 1'b0;
    logic [7:0]  mac_byte = 8'h00;
    logic        mac_last = 1'b0;
    logic [3:0]  mac_err = 4'h0;
    logic        host_rd = 1'b0;
    logic        cmd_discard = 1'b0;
    logic        cmd_rx_reset = 1'b0;
    logic [15:0] status_word;
    logic [15:0] host_rdata;
    logic        rx_complete;
    logic        receiving;
    logic        pkt_limit_hit;
    logic        fifo_full_flag;
    logic        rx_underrun;
    logic        adapter_fail;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    rxq_status_queue #(.DEPTH_BYTES(DEPTH), .MAX_LEN(MAXL), .SLOTS(SLOTS)) dut (
        .clk(clk), .rst_n(rst_n), .mac_valid(mac_valid), .mac_byte(mac_byte),
        .mac_last(mac_last), .mac_err(mac_err), .host_rd(host_rd),
        .cmd_discard(cmd_discard), .cmd_rx_reset(cmd_rx_reset),
        .status_word(status_word), .host_rdata(host_rdata),
        .rx_complete(rx_complete), .receiving(receiving),
        .pkt_limit_hit(pkt_limit_hit), .fifo_full_flag(fifo_full_flag),
        .rx_underrun(rx_underrun), .adapter_fail(adapter_fail)
    );

    // Behavioural reference model
    typedef struct { int len; bit done; int cls; } pkt_t;
    logic [7:0] bq[$];
    pkt_t       pq[$];
    int  m_rdc = 0;
    bit  m_und = 1'b0;
    int  m_st = 0;          // 0 idle, 1 receiving, 2 dropping
    bit  m_ovr = 1'b0;
    bit  m_big = 1'b0;

    function automatic int norm(input logic [3:0] e);
        if (e == 4'b0010 || e == 4'b1000 || e == 4'b1001 || e == 4'b1011 ||
            e == 4'b1100 || e == 4'b1101) return int'(e);
        return 0;
    endfunction

    function automatic int m_remain();
        if (pq.size() == 0) return 0;
        return pq[0].len - m_rdc;
    endfunction

    function automatic logic [15:0] m_status();
        if (pq.size() == 0) return 16'h8000;
        if (!pq[0].done) return {1'b1, 4'b0000, 11'(pq[0].len)};
        return {1'b0, 4'(pq[0].cls), 11'(pq[0].len)};
    endfunction

    function automatic logic [15:0] m_rdata();
        int r = m_remain();
        if (r >= 2) return {bq[1], bq[0]};
        if (r == 1) return {8'h00, bq[0]};
        return 16'h0000;
    endfunction

    task automatic model_clear();
        bq.delete(); pq.delete();
        m_rdc = 0; m_und = 1'b0; m_st = 0; m_ovr = 1'b0; m_big = 1'b0;
    endtask

    task automatic model_step();
        bit pkt_full, byte_full, hd_done;
        int r, n;
        if (!rst_n || cmd_rx_reset) begin
            model_clear();
            return;
        end
        pkt_full  = (pq.size() == SLOTS);
        byte_full = (bq.size() == DEPTH);
        hd_done   = (pq.size() > 0) && pq[0].done;
        r = m_remain();
        if (cmd_discard && hd_done) begin
            for (int i = 0; i < r; i++) void'(bq.pop_front());
            void'(pq.pop_front());
            m_rdc = 0;
        end else if (host_rd) begin
            if (r == 0) m_und = 1'b1;
            else begin
                n = (r >= 2) ? 2 : r;
                for (int i = 0; i < n; i++) void'(bq.pop_front());
                m_rdc += n;
            end
        end
        if (mac_valid) begin
            if (m_st == 0) begin
                if (pkt_full || byte_full) begin
                    if (!mac_last) m_st = 2;
                end else begin
                    pkt_t p;
                    p.len = 1; p.done = mac_last; p.cls = mac_last ? norm(mac_err) : 0;
                    bq.push_back(mac_byte);
                    pq.push_back(p);
                    m_ovr = 1'b0; m_big = 1'b0;
                    if (!mac_last) m_st = 1;
                end
            end else if (m_st == 1) begin
                int k = pq.size() - 1;
                if (pq[k].len == MAXL) m_big = 1'b1;
                else if (byte_full) m_ovr = 1'b1;
                else begin
                    bq.push_back(mac_byte);
                    pq[k].len++;
                end
                if (mac_last) begin
                    pq[k].done = 1'b1;
                    pq[k].cls = m_ovr ? 8 : (m_big ? 9 : norm(mac_err));
                    m_st = 0;
                end
            end else if (mac_last) begin
                m_st = 0;
            end
        end
    endtask

    task automatic check(input logic [15:0] act, input logic [15:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        check(status_word, m_status(), "R2 R3 status word vs model");
        check(host_rdata, m_rdata(), "R7 host data vs model");
        check(16'(rx_complete), 16'((pq.size() > 0) && pq[0].done), "R11 rx_complete vs model");
        check(16'(receiving), 16'(m_st == 1), "R9 receiving vs model");
        check(16'(pkt_limit_hit), 16'(pq.size() == SLOTS), "R5 packet limit vs model");
        check(16'(fifo_full_flag), 16'(bq.size() == DEPTH), "R6 fifo full vs model");
        check(16'(rx_underrun), 16'(m_und), "R8 underrun vs model");
        check(16'(adapter_fail), 16'(m_und), "R8 adapter fail vs model");
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic send(input int len, input logic [3:0] err, input logic [7:0] base, input bit ends);
        for (int i = 0; i < len; i++) begin
            mac_valid = 1'b1;
            mac_byte  = base + 8'(i);
            mac_last  = ends && (i == len - 1);
            mac_err   = (ends && (i == len - 1)) ? err : 4'h0;
            tick();
        end
        mac_valid = 1'b0; mac_last = 1'b0; mac_err = 4'h0;
    endtask

    task automatic read_word();
        host_rd = 1'b1; tick(); host_rd = 1'b0;
    endtask

    task automatic discard();
        cmd_discard = 1'b1; tick(); cmd_discard = 1'b0;
    endtask

    task automatic rx_reset();
        cmd_rx_reset = 1'b1; tick(); cmd_rx_reset = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1: empty after reset
        check(status_word, 16'h8000, "R1 status after reset");
        check({10'd0, rx_complete, receiving, pkt_limit_hit, fifo_full_flag, rx_underrun, adapter_fail},
              16'h0000, "R1 flags after reset");

        // R10: discard on empty queue ignored
        discard();
        check(status_word, 16'h8000, "R10 discard on empty queue");

        // R2, R9: partial frame shows count so far
        send(3, 4'h0, 8'h10, 1'b0);
        check(status_word, 16'h8003, "R2 partial head count");
        check(16'(receiving), 16'h0001, "R9 receiving mid frame");
        // R10: discard of an arriving head ignored
        discard();
        check(status_word, 16'h8003, "R10 discard while arriving");
        send(2, 4'b1101, 8'h13, 1'b1);
        tick();
        // R3, R11: CRC class, 5 bytes
        check(status_word, 16'h6805, "R3 CRC class status");
        check(16'(rx_complete), 16'h0001, "R11 complete at head");
        check(16'(receiving), 16'h0000, "R9 receiving after end");
        // R7: word reads, low byte first, odd tail
        check(host_rdata, 16'h1110, "R7 first word");
        read_word();
        check(host_rdata, 16'h1312, "R7 second word");
        read_word();
        check(host_rdata, 16'h0014, "R7 odd last byte");
        read_word();
        check(16'(rx_underrun), 16'h0000, "R8 no underrun within packet");
        // R8: read past end
        read_word();
        check({14'd0, rx_underrun, adapter_fail}, 16'h0003, "R8 underrun raised");
        discard();
        check(status_word, 16'h8000, "R10 discard removes head");
        check(16'(rx_underrun), 16'h0001, "R8 underrun sticky over discard");
        // R12: RX reset clears
        rx_reset();
        check(16'(rx_underrun), 16'h0000, "R12 underrun cleared by rx reset");

        // R3: unknown code and dribble
        send(3, 4'b0111, 8'h20, 1'b1);
        tick();
        check(status_word, 16'h0003, "R3 unknown code no error");
        discard();
        send(3, 4'b0010, 8'h30, 1'b1);
        tick();
        check(status_word, 16'h1003, "R3 dribble class");
        discard();
        send(2, 4'b1011, 8'h38, 1'b1);
        tick();
        check(status_word, 16'h5802, "R3 runt class");
        discard();

        // R4: oversize truncated at MAXL
        send(25, 4'b1101, 8'h40, 1'b1);
        tick();
        check(status_word, 16'h4814, "R4 oversize class and count");
        discard();

        // R5: eight packet limit
        for (int p = 0; p < 8; p++) send(2, 4'h0, 8'(8'h60 + 2 * p), 1'b1);
        tick();
        check(16'(pkt_limit_hit), 16'h0001, "R5 limit at eight");
        send(2, 4'h0, 8'hA0, 1'b1);
        check(16'(receiving), 16'h0000, "R9 refused frame not receiving");
        check(16'(pkt_limit_hit), 16'h0001, "R5 limit after refused frame");
        discard();
        check(16'(pkt_limit_hit), 16'h0000, "R5 limit clears after discard");
        check(host_rdata, 16'h6362, "R5 head after discard is second packet");
        send(2, 4'h0, 8'hB0, 1'b1);
        for (int p = 0; p < 7; p++) discard();
        check(host_rdata, 16'hB1B0, "R5 refused frame absent, later frame kept");
        discard();
        check(status_word, 16'h8000, "R5 queue empty after all discards");

        // R6: FIFO fills mid frame
        rx_reset();
        send(20, 4'h0, 8'h00, 1'b1);
        send(20, 4'b1101, 8'h80, 1'b1);
        tick();
        check(16'(fifo_full_flag), 16'h0001, "R6 fifo full flag");
        send(3, 4'h0, 8'hC0, 1'b1);
        check(16'(receiving), 16'h0000, "R6 refused on full fifo");
        check(status_word, 16'h0014, "R6 head unaffected");
        read_word();
        check(16'(fifo_full_flag), 16'h0000, "R6 flag clears after read");
        discard();
        check(status_word, 16'h400C, "R6 truncated frame overrun class");
        check(host_rdata, 16'h8180, "R6 truncated frame data");
        discard();
        check(status_word, 16'h8000, "R6 refused frame absent");

        // R10: read in same cycle as discard has no effect
        send(4, 4'h0, 8'hD0, 1'b1);
        send(2, 4'h0, 8'hE0, 1'b1);
        host_rd = 1'b1; cmd_discard = 1'b1; tick(); host_rd = 1'b0; cmd_discard = 1'b0;
        check(host_rdata, 16'hE1E0, "R10 read during discard ignored");

        // R12: reset during a frame
        send(3, 4'h0, 8'hF0, 1'b0);
        rx_reset();
        check(status_word, 16'h8000, "R12 flush mid frame");
        check(16'(receiving), 16'h0000, "R12 receiving cleared");
        tick();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule